// File: doc/BRIEF.md
# Coherent Port Snoop Enable Controller

This block holds the snoop and distributed-virtual-memory (DVM) message enables of a set of slave-interface ports on a coherent interconnect. Software reaches it through a simple register bus. Each port has its own control register. One shared status register shows whether any enable change is still waiting to be taken up.

The ports come in two kinds: full-coherency ports and I/O-coherency ports. The full-coherency ports are numbered first and the I/O-coherency ports follow them. The port count is the sum of the two kinds.

A change of enables is not instant. When a write alters a port's enable pair, that port's request line is raised toward the attached master. The request stays high until the master acknowledges the new state. Software writes a control word and then polls the status bit until it reads zero.

Top module: `portSnoopCtl`

## Requirements
- R1: After reset, every snoop enable, every DVM enable and every request is 0, and the status register reads 0.
- R2: The control register of port p sits at byte address (p+1)*16. Bit 0 of the written word drives portSnoopEn[p] and bit 1 drives portDvmEn[p]. Both outputs take the new value on the clock edge that accepts the write. A word of 0x3 enables both, and 0x0 disables both.
- R3: A control write whose two enable bits differ from the port's current pair raises portReq[p] on the same edge. portReq[p] then stays high on every cycle until an acknowledge is taken.
- R4: portAck[p], sampled while portReq[p] is high, clears the request on that edge. When a changing write to the same port arrives on the same edge, the write wins and the request stays high.
- R5: A control write that repeats the port's current enable pair leaves portReq[p] low if it was low.
- R6: The status register at byte address 0x0C returns in bit 0 the OR of all port requests. Its other bits read 0.
- R7: A read of a control register returns the last enable bits written to it in bits 1:0. All other bits read 0, and writes to those other bits have no effect.
- R8: A write to the status address or to any undecoded address changes no enable and no request. A read of an undecoded address returns 0.
- R9: portAck[p] while portReq[p] is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | DATA_W | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | DATA_W | Read data, valid in the cycle of regRdEn, 0 otherwise |
| portSnoopEn | output | NUM_FULL+NUM_LITE | Snoop enable per port |
| portDvmEn | output | NUM_FULL+NUM_LITE | DVM message enable per port |
| portReq | output | NUM_FULL+NUM_LITE | Enable-change request per port, held until acknowledged |
| portAck | input | NUM_FULL+NUM_LITE | Acknowledge per port from the attached master |

## Verification
On every cycle, the assertions check the following:
- a request only rises after a changing write to its own port;
- a request is held while no acknowledge arrives, and drops after an acknowledge when no write competes with it;
- a repeated write raises nothing;
- enables move only under a write to their own port;
- the status bit always matches the OR of the requests.

The bench's scenarios show the rest:
- the address map and the readback values;
- masking of the reserved bits;
- a write that arrives on the same edge as an acknowledge;
- stray acknowledges;
- writes to the status address and to undecoded addresses.

The bench compares these against a behavioural model on every clock.

// File: rtl/snoopCtlPkg.sv
package snoopCtlPkg;
  localparam int SNOOP_BIT = 0;
  localparam int DVM_BIT = 1;
  localparam logic [3:0] STATUS_OFS = 4'hC;

  typedef struct packed {
    logic       wrValid;
    logic [1:0] wrBits;
    logic       rdStatus;
    logic       rdPort;
  } strobeT;
endpackage

// File: rtl/snoopRegDecode.sv
module snoopRegDecode
  import snoopCtlPkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int ADDR_W = 8,
  parameter int WIN_SHIFT = 4,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic                 rdEn,
  input  logic [DATA_W-1:0]    wrData,
  output strobeT               strobe,
  output logic [NUM_PORTS-1:0] portSel
);
  localparam int WIN_W = ADDR_W - WIN_SHIFT;

  logic [NUM_PORTS-1:0] portHit;
  logic statusHit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
    assign portHit[p] = (addr[ADDR_W-1:WIN_SHIFT] == WIN_W'(p + 1)) &&
                        (addr[WIN_SHIFT-1:0] == '0);
  end

  assign statusHit = (addr == ADDR_W'(STATUS_OFS));

  always_comb begin
    portSel         = portHit & {NUM_PORTS{wrEn | rdEn}};
    strobe.wrValid  = wrEn && (|portHit);
    strobe.wrBits   = wrData[1:0];
    strobe.rdStatus = rdEn && statusHit;
    strobe.rdPort   = rdEn && (|portHit);
  end
endmodule

// File: rtl/snoopPortBank.sv
module snoopPortBank
  import snoopCtlPkg::*;
#(
  parameter int NUM_PORTS = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               strobe,
  input  logic [NUM_PORTS-1:0] portSel,
  input  logic [NUM_PORTS-1:0] portAck,
  output logic [NUM_PORTS-1:0] snoopEn,
  output logic [NUM_PORTS-1:0] dvmEn,
  output logic [NUM_PORTS-1:0] pending,
  output logic                 anyPending,
  output logic [1:0]           selBits
);
  logic [1:0] bitsMasked [NUM_PORTS];

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    logic [1:0] enQ;
    logic pendQ;
    logic hitWr;
    logic changeWr;

    assign hitWr = portSel[i] && strobe.wrValid;
    assign changeWr = hitWr && (strobe.wrBits != enQ);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enQ <= '0;
        pendQ <= 1'b0;
      end else begin
        if (hitWr) enQ <= strobe.wrBits;
        if (changeWr) pendQ <= 1'b1;
        else if (portAck[i]) pendQ <= 1'b0;
      end
    end

    assign snoopEn[i] = enQ[SNOOP_BIT];
    assign dvmEn[i] = enQ[DVM_BIT];
    assign pending[i] = pendQ;
    assign bitsMasked[i] = portSel[i] ? enQ : 2'b00;

    p_req_rise_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pending[i]) |-> $past(portSel[i] && strobe.wrValid));
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (pending[i] && !portAck[i]) |=> pending[i]);
    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      (pending[i] && portAck[i] && !(portSel[i] && strobe.wrValid)) |=> !pending[i]);
    p_same_write_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!pending[i] && portSel[i] && strobe.wrValid &&
       strobe.wrBits == {dvmEn[i], snoopEn[i]}) |=> !pending[i]);
    p_en_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
      !(portSel[i] && strobe.wrValid) |=> $stable({dvmEn[i], snoopEn[i]}));
  end

  always_comb begin
    selBits = 2'b00;
    for (int i = 0; i < NUM_PORTS; i++) selBits = selBits | bitsMasked[i];
  end

  assign anyPending = |pending;
endmodule

// File: rtl/portSnoopCtl.sv
module portSnoopCtl
  import snoopCtlPkg::*;
#(
  parameter int NUM_FULL = 2,
  parameter int NUM_LITE = 3,
  parameter int ADDR_W = 8,
  parameter int WIN_SHIFT = 4,
  parameter int DATA_W = 32,
  localparam int NUM_PORTS = NUM_FULL + NUM_LITE
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 regRdEn,
  output logic [DATA_W-1:0]    regRdData,
  output logic [NUM_PORTS-1:0] portSnoopEn,
  output logic [NUM_PORTS-1:0] portDvmEn,
  output logic [NUM_PORTS-1:0] portReq,
  input  logic [NUM_PORTS-1:0] portAck
);
  strobeT strobe;
  logic [NUM_PORTS-1:0] portSel;
  logic anyPending;
  logic [1:0] selBits;

  snoopRegDecode #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .DATA_W(DATA_W)
  ) u_decode (
    .addr(regAddr), .wrEn(regWrEn), .rdEn(regRdEn), .wrData(regWrData),
    .strobe(strobe), .portSel(portSel)
  );

  snoopPortBank #(.NUM_PORTS(NUM_PORTS)) u_bank (
    .clk(clk), .rstN(rstN), .strobe(strobe), .portSel(portSel), .portAck(portAck),
    .snoopEn(portSnoopEn), .dvmEn(portDvmEn), .pending(portReq),
    .anyPending(anyPending), .selBits(selBits)
  );

  always_comb begin
    regRdData = '0;
    if (strobe.rdStatus) regRdData[0] = anyPending;
    else if (strobe.rdPort) regRdData[1:0] = selBits;
  end

  p_status_or_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(STATUS_OFS)) |->
      (regRdData == DATA_W'(|portReq)));
endmodule

// File: tb/portSnoopCtl_bench.sv
module portSnoopCtl_bench;
  localparam int NP = 5;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 0;
  logic rstN = 0;
  logic [AW-1:0] regAddr = '0;
  logic regWrEn = 0;
  logic [DW-1:0] regWrData = '0;
  logic regRdEn = 0;
  logic [DW-1:0] regRdData;
  logic [NP-1:0] portSnoopEn, portDvmEn, portReq;
  logic [NP-1:0] portAck = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit [1:0] mEn [NP];
  bit mPend [NP];

  always #10 clk = ~clk;

  portSnoopCtl u_portSnoopCtl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .portSnoopEn(portSnoopEn), .portDvmEn(portDvmEn), .portReq(portReq),
    .portAck(portAck)
  );

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NP; p++) begin mEn[p] = 0; mPend[p] = 0; end
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (regWrEn && regAddr == AW'((p + 1) * 16)) begin
          if (regWrData[1:0] != mEn[p]) mPend[p] = 1;
          else if (portAck[p]) mPend[p] = 0;
          mEn[p] = regWrData[1:0];
        end else if (portAck[p]) mPend[p] = 0;
      end
    end
  end

  function automatic bit mStatus();
    bit s = 0;
    for (int p = 0; p < NP; p++) s |= mPend[p];
    return s;
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int p = 0; p < NP; p++) begin
        checks++;
        if (portSnoopEn[p] !== mEn[p][0] || portDvmEn[p] !== mEn[p][1]) begin
          failures++;
          $display("FAIL R2 port %0d enables actual=%0b%0b expected=%0b%0b",
                   p, portDvmEn[p], portSnoopEn[p], mEn[p][1], mEn[p][0]);
        end
        checks++;
        if (portReq[p] !== mPend[p]) begin
          failures++;
          $display("FAIL R3 port %0d request actual=%0b expected=%0b", p, portReq[p], mPend[p]);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input logic [NP-1:0] ack = '0);
    @(negedge clk);
    regAddr = AW'(a); regWrData = DW'(d); regWrEn = 1; portAck = ack;
    @(negedge clk);
    regWrEn = 0; portAck = '0;
  endtask

  task automatic ackPulse(input logic [NP-1:0] ack);
    @(negedge clk);
    portAck = ack;
    @(negedge clk);
    portAck = '0;
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    regAddr = AW'(a); regRdEn = 1;
    #5 check(tag, regRdData, exp);
    #1 regRdEn = 0;
  endtask

  function automatic int pa(input int p);
    return (p + 1) * 16;
  endfunction

  initial begin
    #(20 * 5000);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    @(negedge clk);
    check("R1 snoop", DW'(portSnoopEn), 0);
    check("R1 dvm", DW'(portDvmEn), 0);
    check("R1 req", DW'(portReq), 0);
    rd(12, 0, "R1 status");
    // R2 R3 full enable of port 0
    wr(pa(0), 3);
    check("R2 port0 enabled", DW'({portDvmEn[0], portSnoopEn[0]}), 3);
    check("R3 port0 req", DW'(portReq[0]), 1);
    rd(12, 1, "R6 status pending");
    rd(pa(0), 3, "R7 readback port0");
    repeat (4) @(negedge clk);
    check("R3 req held", DW'(portReq[0]), 1);
    // R4 ack clears
    ackPulse(5'b00001);
    check("R4 req cleared", DW'(portReq[0]), 0);
    rd(12, 0, "R6 status clear");
    // R5 same value write
    wr(pa(0), 3);
    check("R5 no req", DW'(portReq[0]), 0);
    // R7 reserved bits
    wr(pa(1), 'hFFFF_FFFD);
    rd(pa(1), 1, "R7 reserved masked");
    // R6 two pending, ack one
    wr(pa(4), 2);
    rd(12, 1, "R6 two pending");
    ackPulse(5'b00010);
    rd(12, 1, "R6 one still pending");
    ackPulse(5'b10000);
    rd(12, 0, "R6 none pending");
    // R8 writes to status/undecoded ignored
    wr(12, 3);
    wr(4, 3);
    wr('hF0, 3);
    wr(pa(2) + 4, 3);
    check("R8 no req", DW'(portReq), 0);
    check("R8 port2 off", DW'({portDvmEn[2], portSnoopEn[2]}), 0);
    rd('hF0, 0, "R8 undecoded read");
    rd(pa(2) + 8, 0, "R8 offset read");
    // R9 stray ack
    ackPulse('1);
    check("R9 enables kept", DW'({portDvmEn[0], portSnoopEn[0]}), 3);
    check("R9 req low", DW'(portReq), 0);
    // R4 changing write on same edge as ack keeps pending
    wr(pa(3), 1);
    wr(pa(3), 3, 5'b01000);
    check("R4 write wins", DW'(portReq[3]), 1);
    ackPulse(5'b01000);
    check("R4 cleared after", DW'(portReq[3]), 0);
    // R2 disable
    wr(pa(0), 0);
    check("R2 port0 disabled", DW'({portDvmEn[0], portSnoopEn[0]}), 0);
    check("R3 disable req", DW'(portReq[0]), 1);
    ackPulse(5'b00001);
    rd(pa(0), 0, "R7 readback disabled");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule